// File: doc/BRIEF.md
# Bus Burst Cycle Monitor

This block watches the master side of a pipelined-capable Wishbone B3 port without driving anything on it. On each rising clock edge it looks at the cycle, write-enable, three-bit cycle-type identifier and acknowledge lines. Every beat where both cycle and acknowledge are high is sorted into one of four kinds: a classic single transfer, an incrementing burst beat, an end-of-burst beat, or an illegal type. From that sort it keeps four saturating 16-bit totals: single reads, single writes, completed read bursts and completed write bursts.

A burst is legal only when exactly `BURST_LEN - 1` incrementing beats come before its end-of-burst beat. A single transfer in the middle of a burst, an end beat after too few or too many incrementing beats, or any unassigned cycle-type code sets a sticky error flag. A two-bit code keeps the first error seen. A clear strobe drops the flag and code without touching the totals or the burst position. The monitor is meant to sit beside a bus master in a larger design or in a bench, as a cheap protocol watchdog and traffic profile.

Two small state machines carry the control. The burst sequencer has the states `SEQ_IDLE` (no beats of a burst seen) and `SEQ_BURST` (one or more incrementing beats seen). Its transitions are *open* (`SEQ_IDLE` to `SEQ_BURST` on an incrementing beat), *extend* (`SEQ_BURST` to `SEQ_BURST` on an incrementing beat), *close* (`SEQ_BURST` to `SEQ_IDLE` on an end beat at the exact length) and *hold* (any other beat or idle clock leaves the state as it is). The error tracker has the states `ERR_CLEAN` and `ERR_HELD`. Its transitions are *trip* (`ERR_CLEAN` to `ERR_HELD` on a violation), *wipe* (`ERR_HELD` to `ERR_CLEAN` on the clear strobe with no violation) and *re-arm* (stay in `ERR_HELD` and load the new code when a violation and the clear strobe come together).

Top module: `bus_burst_monitor`

## Requirements
- R1: A clock where `bus_cyc` and `bus_ack` are not both high changes no total, no burst position and no error state, whatever `bus_we` and `bus_cti` hold.
- R2: An acknowledged beat with `bus_cti` = 3'b000 while the burst position is zero adds one to `single_wr_cnt` when `bus_we` = 1, and adds one to `single_rd_cnt` when `bus_we` = 0.
- R3: An acknowledged beat with `bus_cti` = 3'b000 while the burst position is nonzero changes no total and sets `err_flag` with `err_code` = 2'd1.
- R4: An acknowledged beat with `bus_cti` = 3'b010 raises the burst position by one. An acknowledged beat with `bus_cti` = 3'b111 while the position equals `BURST_LEN - 1` adds one to `burst_wr_cnt` when `bus_we` = 1, or to `burst_rd_cnt` when `bus_we` = 0, and returns the position to zero.
- R5: An acknowledged beat with `bus_cti` = 3'b111 at any other burst position, or with a `bus_cti` code other than 3'b000, 3'b010 or 3'b111, changes no total and no burst position, and sets `err_flag` with `err_code` = 2'd2.
- R6: Once set, `err_flag` stays high and `err_code` keeps the code of the first violation until reset or clear. `err_code` is 2'd0 whenever `err_flag` is low and nonzero whenever it is high.
- R7: A high `clr_err` clears `err_flag` and `err_code` to zero on the next edge and leaves the totals and burst position unchanged. If a violating beat comes in the same clock, the flag is set again with that beat's code.
- R8: Each of the four 16-bit totals stops at 16'hFFFF and stays there on further qualifying beats.
- R9: A synchronous active-high `rst` zeroes the four totals, the burst position, `err_flag` and `err_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc | input | 1 | Observed bus cycle line |
| bus_we | input | 1 | Observed write-enable line |
| bus_cti | input | 3 | Observed cycle-type identifier |
| bus_ack | input | 1 | Observed slave acknowledge |
| clr_err | input | 1 | Clears the error flag and code |
| single_rd_cnt | output | 16 | Saturating total of single reads |
| single_wr_cnt | output | 16 | Saturating total of single writes |
| burst_rd_cnt | output | 16 | Saturating total of completed read bursts |
| burst_wr_cnt | output | 16 | Saturating total of completed write bursts |
| err_flag | output | 1 | Sticky protocol violation flag |
| err_code | output | 2 | First violation: 1 single inside burst, 2 bad type or length |

## Verification
The properties assume that every bus input is a known 0 or 1 on each rising edge once reset is released. They also assume that `rst` is held high across the first edge, so the burst position and the error state start defined. The bench drives every input on the falling edge, starts with reset asserted, and never leaves a line floating. It also holds `clr_err` low outside deliberate pulses, so the sticky-flag property sees only intended clears. Illegal cycle-type codes and wrong burst lengths are produced on purpose, because the assertions cover those violation paths as well as clean traffic.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    // Cycle-type identifier codes the monitor understands
    localparam logic [2:0] CTI_CLASSIC = 3'b000;
    localparam logic [2:0] CTI_INCR    = 3'b010;
    localparam logic [2:0] CTI_LAST    = 3'b111;

    // Classification of one bus clock
    typedef enum logic [2:0] {
        BEAT_NONE,
        BEAT_SINGLE,
        BEAT_INCR,
        BEAT_END,
        BEAT_BAD
    } beat_kind_e;

    // Violation codes reported on err_code
    typedef enum logic [1:0] {
        ERRC_NONE   = 2'd0,
        ERRC_NESTED = 2'd1,
        ERRC_PROTO  = 2'd2
    } err_code_e;

    // Burst sequencer states
    typedef enum logic {
        SEQ_IDLE,
        SEQ_BURST
    } seq_state_e;

    // Error tracker states
    typedef enum logic {
        ERR_CLEAN,
        ERR_HELD
    } err_state_e;

endpackage

// File: rtl/bbm_beat_decode.sv
module bbm_beat_decode
    import bbm_pkg::*;
(
    input  logic       cyc,
    input  logic       ack,
    input  logic [2:0] cti,
    output beat_kind_e kind
);

    always_comb begin
        if (!(cyc && ack)) begin
            kind = BEAT_NONE;
        end else begin
            unique case (cti)
                CTI_CLASSIC: kind = BEAT_SINGLE;
                CTI_INCR:    kind = BEAT_INCR;
                CTI_LAST:    kind = BEAT_END;
                default:     kind = BEAT_BAD;
            endcase
        end
    end

endmodule

// File: rtl/bbm_burst_seq.sv
module bbm_burst_seq
    import bbm_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int CW        = $clog2(BURST_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  beat_kind_e    kind,
    input  logic          we,
    output logic          ev_single_rd,
    output logic          ev_single_wr,
    output logic          ev_burst_rd,
    output logic          ev_burst_wr,
    output logic          ev_err,
    output err_code_e     ev_code,
    output logic [CW-1:0] beat_cnt
);

    // Position that makes an end beat legal, and the ceiling of the position
    localparam logic [CW-1:0] LAST_POS = CW'(BURST_LEN - 1);
    localparam logic [CW-1:0] CAP_POS  = CW'(BURST_LEN);

    seq_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] cnt_bump;

    // The position stops at CAP_POS so an overlong burst stays detectable
    assign cnt_bump = (cnt_q == CAP_POS) ? cnt_q : cnt_q + 1'b1;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and beat events
    always_comb begin
        state_d      = state_q;
        cnt_d        = cnt_q;
        ev_single_rd = 1'b0;
        ev_single_wr = 1'b0;
        ev_burst_rd  = 1'b0;
        ev_burst_wr  = 1'b0;
        ev_err       = 1'b0;
        ev_code      = ERRC_NONE;
        unique case (state_q)
            SEQ_IDLE: begin
                unique case (kind)
                    BEAT_NONE: begin
                    end
                    BEAT_SINGLE: begin
                        ev_single_wr = we;
                        ev_single_rd = !we;
                    end
                    BEAT_INCR: begin
                        // open
                        cnt_d   = cnt_bump;
                        state_d = SEQ_BURST;
                    end
                    BEAT_END: begin
                        // Only a one-beat burst may end from idle
                        if (cnt_q == LAST_POS) begin
                            ev_burst_wr = we;
                            ev_burst_rd = !we;
                        end else begin
                            ev_err  = 1'b1;
                            ev_code = ERRC_PROTO;
                        end
                    end
                    default: begin
                        ev_err  = 1'b1;
                        ev_code = ERRC_PROTO;
                    end
                endcase
            end
            SEQ_BURST: begin
                unique case (kind)
                    BEAT_NONE: begin
                    end
                    BEAT_SINGLE: begin
                        ev_err  = 1'b1;
                        ev_code = ERRC_NESTED;
                    end
                    BEAT_INCR: begin
                        // extend
                        cnt_d = cnt_bump;
                    end
                    BEAT_END: begin
                        if (cnt_q == LAST_POS) begin
                            // close
                            ev_burst_wr = we;
                            ev_burst_rd = !we;
                            cnt_d       = '0;
                            state_d     = SEQ_IDLE;
                        end else begin
                            ev_err  = 1'b1;
                            ev_code = ERRC_PROTO;
                        end
                    end
                    default: begin
                        ev_err  = 1'b1;
                        ev_code = ERRC_PROTO;
                    end
                endcase
            end
            default: begin
                state_d = SEQ_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    assign beat_cnt = cnt_q;

endmodule

// File: rtl/bbm_err_track.sv
module bbm_err_track
    import bbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       ev_err,
    input  err_code_e  ev_code,
    output logic       err_flag,
    output logic [1:0] err_code
);

    err_state_e state_q, state_d;
    err_code_e  code_q, code_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ERR_CLEAN;
            code_q  <= ERRC_NONE;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        unique case (state_q)
            ERR_CLEAN: begin
                if (ev_err) begin
                    // trip
                    state_d = ERR_HELD;
                    code_d  = ev_code;
                end
            end
            ERR_HELD: begin
                if (clr && ev_err) begin
                    // re-arm: the clear drops the old code, the new beat is kept
                    code_d = ev_code;
                end else if (clr) begin
                    // wipe
                    state_d = ERR_CLEAN;
                    code_d  = ERRC_NONE;
                end
            end
            default: begin
                state_d = ERR_CLEAN;
                code_d  = ERRC_NONE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        err_flag = (state_q == ERR_HELD);
        err_code = code_q;
    end

endmodule

// File: rtl/bbm_sat_cnt.sv
module bbm_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (inc && (cnt_q != TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/bus_burst_monitor.sv
module bus_burst_monitor
    import bbm_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_cyc,
    input  logic             bus_we,
    input  logic [2:0]       bus_cti,
    input  logic             bus_ack,
    input  logic             clr_err,
    output logic [CNT_W-1:0] single_rd_cnt,
    output logic [CNT_W-1:0] single_wr_cnt,
    output logic [CNT_W-1:0] burst_rd_cnt,
    output logic [CNT_W-1:0] burst_wr_cnt,
    output logic             err_flag,
    output logic [1:0]       err_code
);

    localparam int CW      = $clog2(BURST_LEN + 1);
    localparam int NUM_CNT = 4;

    beat_kind_e       kind;
    logic             ev_single_rd, ev_single_wr, ev_burst_rd, ev_burst_wr;
    logic             ev_err;
    err_code_e        ev_code;
    logic [CW-1:0]    beat_cnt;
    logic [NUM_CNT-1:0] inc_vec;
    logic [CNT_W-1:0] cnt_arr [NUM_CNT];

    bbm_beat_decode u_decode (
        .cyc  (bus_cyc),
        .ack  (bus_ack),
        .cti  (bus_cti),
        .kind (kind)
    );

    bbm_burst_seq #(
        .BURST_LEN (BURST_LEN),
        .CW        (CW)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .kind         (kind),
        .we           (bus_we),
        .ev_single_rd (ev_single_rd),
        .ev_single_wr (ev_single_wr),
        .ev_burst_rd  (ev_burst_rd),
        .ev_burst_wr  (ev_burst_wr),
        .ev_err       (ev_err),
        .ev_code      (ev_code),
        .beat_cnt     (beat_cnt)
    );

    bbm_err_track u_err (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_err),
        .ev_err   (ev_err),
        .ev_code  (ev_code),
        .err_flag (err_flag),
        .err_code (err_code)
    );

    // Counter slots: 0 single read, 1 single write, 2 burst read, 3 burst write
    assign inc_vec = {ev_burst_wr, ev_burst_rd, ev_single_wr, ev_single_rd};

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_total
        bbm_sat_cnt #(
            .W (CNT_W)
        ) u_cnt (
            .clk (clk),
            .rst (rst),
            .inc (inc_vec[g]),
            .cnt (cnt_arr[g])
        );
    end

    assign single_rd_cnt = cnt_arr[0];
    assign single_wr_cnt = cnt_arr[1];
    assign burst_rd_cnt  = cnt_arr[2];
    assign burst_wr_cnt  = cnt_arr[3];

endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
    parameter int BURST_LEN = 4,
    parameter int CNT_W     = 16,
    parameter int CW        = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_cyc,
    input logic             bus_we,
    input logic [2:0]       bus_cti,
    input logic             bus_ack,
    input logic             clr_err,
    input logic [CNT_W-1:0] single_rd_cnt,
    input logic [CNT_W-1:0] single_wr_cnt,
    input logic [CNT_W-1:0] burst_rd_cnt,
    input logic [CNT_W-1:0] burst_wr_cnt,
    input logic             err_flag,
    input logic [1:0]       err_code,
    input logic [CW-1:0]    beat_cnt
);

    localparam logic [CNT_W-1:0] MAXV     = {CNT_W{1'b1}};
    localparam logic [CW-1:0]    LAST_POS = CW'(BURST_LEN - 1);

    logic live;
    logic legal_type;
    logic prev_rst;

    assign live       = bus_cyc && bus_ack;
    assign legal_type = (bus_cti == 3'b000) || (bus_cti == 3'b010) || (bus_cti == 3'b111);

    always_ff @(posedge clk) prev_rst <= rst;

    AST_QUIET_BUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !live |=> $stable({single_rd_cnt, single_wr_cnt, burst_rd_cnt, burst_wr_cnt, beat_cnt})); // R1

    AST_SINGLE_WR_STEP: assert property (@(posedge clk) disable iff (rst)
        (live && bus_cti == 3'b000 && bus_we && beat_cnt == '0 && single_wr_cnt != MAXV)
        |=> single_wr_cnt == CNT_W'($past(single_wr_cnt) + 1'b1)); // R2

    AST_NESTED_SINGLE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (live && bus_cti == 3'b000 && beat_cnt != '0 && !err_flag && !clr_err)
        |=> err_flag && err_code == 2'd1); // R3

    AST_BURST_CLOSE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (live && bus_cti == 3'b111 && beat_cnt == LAST_POS) |=> beat_cnt == '0); // R4

    AST_BAD_TYPE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (live && !legal_type && !err_flag) |=> err_flag && err_code == 2'd2); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !clr_err) |=> err_flag && $stable(err_code)); // R6

    AST_CODE_TRACKS_FLAG: assert property (@(posedge clk) disable iff (rst)
        err_flag == (err_code != 2'd0)); // R6

    AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (rst)
        (clr_err && !live) |=> !err_flag && err_code == 2'd0); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (single_rd_cnt == MAXV) |=> single_rd_cnt == MAXV); // R8

    AST_RESET_ZERO: assert property (@(posedge clk)
        (prev_rst === 1'b1) |-> (single_rd_cnt == '0 && single_wr_cnt == '0 &&
                                 burst_rd_cnt == '0 && burst_wr_cnt == '0 &&
                                 beat_cnt == '0 && !err_flag && err_code == 2'd0)); // R9

endmodule

bind bus_burst_monitor bbm_checker #(
    .BURST_LEN (BURST_LEN),
    .CNT_W     (CNT_W),
    .CW        (CW)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .bus_cyc       (bus_cyc),
    .bus_we        (bus_we),
    .bus_cti       (bus_cti),
    .bus_ack       (bus_ack),
    .clr_err       (clr_err),
    .single_rd_cnt (single_rd_cnt),
    .single_wr_cnt (single_wr_cnt),
    .burst_rd_cnt  (burst_rd_cnt),
    .burst_wr_cnt  (burst_wr_cnt),
    .err_flag      (err_flag),
    .err_code      (err_code),
    .beat_cnt      (beat_cnt)
);

// File: tb/bus_burst_monitor_tb_top.sv
`timescale 1ns/1ps
module bus_burst_monitor_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_cyc = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_cti = 3'b000;
    logic        bus_ack = 1'b0;
    logic        clr_err = 1'b0;
    logic [15:0] single_rd_cnt, single_wr_cnt, burst_rd_cnt, burst_wr_cnt;
    logic        err_flag;
    logic [1:0]  err_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    bus_burst_monitor dut_i (
        .clk           (clk),
        .rst           (rst),
        .bus_cyc       (bus_cyc),
        .bus_we        (bus_we),
        .bus_cti       (bus_cti),
        .bus_ack       (bus_ack),
        .clr_err       (clr_err),
        .single_rd_cnt (single_rd_cnt),
        .single_wr_cnt (single_wr_cnt),
        .burst_rd_cnt  (burst_rd_cnt),
        .burst_wr_cnt  (burst_wr_cnt),
        .err_flag      (err_flag),
        .err_code      (err_code)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input int srd, input int swr,
                             input int brd, input int bwr, input int flag, input int code);
        check({tag, " single_rd"}, single_rd_cnt, srd);
        check({tag, " single_wr"}, single_wr_cnt, swr);
        check({tag, " burst_rd"},  burst_rd_cnt,  brd);
        check({tag, " burst_wr"},  burst_wr_cnt,  bwr);
        check({tag, " err_flag"},  err_flag,      flag);
        check({tag, " err_code"},  err_code,      code);
    endtask

    // One clock of bus activity, driven on the falling edge; returns on the next falling edge
    task automatic beat(input bit cyc, input bit ack, input bit we, input bit [2:0] cti, input bit clr);
        bus_cyc = cyc; bus_ack = ack; bus_we = we; bus_cti = cti; clr_err = clr;
        @(negedge clk);
        bus_cyc = 1'b0; bus_ack = 1'b0; bus_we = 1'b0; bus_cti = 3'b000; clr_err = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic burst(input bit we, input int incr_beats);
        for (int i = 0; i < incr_beats; i++) beat(1, 1, we, 3'b010, 0);
        beat(1, 1, we, 3'b111, 0);
    endtask

    task automatic t_reset();
        do_reset();
        check_all("R9 after reset", 0, 0, 0, 0, 0, 0);
        beat(1, 1, 1, 3'b000, 0);
        beat(1, 1, 0, 3'b010, 0);
        beat(1, 1, 0, 3'b010, 0);
        do_reset();
        check_all("R9 reset clears totals", 0, 0, 0, 0, 0, 0);
        // Position was cleared, so an end beat now is a length violation
        beat(1, 1, 0, 3'b111, 0);
        check_all("R9 reset clears position", 0, 0, 0, 0, 1, 2);
    endtask

    task automatic t_quiet();
        do_reset();
        beat(1, 0, 1, 3'b000, 0);
        beat(0, 1, 0, 3'b101, 0);
        beat(1, 0, 0, 3'b010, 0);
        beat(0, 1, 0, 3'b010, 0);
        check_all("R1 unacked clocks", 0, 0, 0, 0, 0, 0);
        beat(1, 1, 1, 3'b000, 0);
        check_all("R1 position untouched", 0, 1, 0, 0, 0, 0);
    endtask

    task automatic t_singles();
        do_reset();
        beat(1, 1, 1, 3'b000, 0);
        beat(1, 1, 0, 3'b000, 0);
        beat(1, 1, 1, 3'b000, 0);
        beat(1, 1, 1, 3'b000, 0);
        beat(1, 1, 0, 3'b000, 0);
        check_all("R2 singles", 2, 3, 0, 0, 0, 0);
    endtask

    task automatic t_bursts();
        do_reset();
        burst(1, 3);
        check_all("R4 write burst", 0, 0, 0, 1, 0, 0);
        burst(0, 3);
        burst(0, 3);
        check_all("R4 read bursts", 0, 0, 2, 1, 0, 0);
        beat(1, 1, 0, 3'b000, 0);
        check_all("R4 position back to zero", 1, 0, 2, 1, 0, 0);
    endtask

    task automatic t_nested();
        do_reset();
        beat(1, 1, 1, 3'b010, 0);
        beat(1, 1, 1, 3'b000, 0);
        check_all("R3 single inside burst", 0, 0, 0, 0, 1, 1);
    endtask

    task automatic t_bad();
        do_reset();
        burst(1, 2);
        check_all("R5 short burst", 0, 0, 0, 0, 1, 2);
        do_reset();
        burst(0, 4);
        check_all("R5 long burst", 0, 0, 0, 0, 1, 2);
        do_reset();
        beat(1, 1, 0, 3'b001, 0);
        check_all("R5 type 001", 0, 0, 0, 0, 1, 2);
        do_reset();
        beat(1, 1, 1, 3'b010, 0);
        beat(1, 1, 1, 3'b110, 0);
        beat(1, 1, 1, 3'b010, 0);
        beat(1, 1, 1, 3'b010, 0);
        beat(1, 1, 1, 3'b111, 0);
        // Bad beat left the position alone, so the burst still closes at its proper length
        check_all("R5 position kept", 0, 0, 0, 1, 1, 2);
    endtask

    task automatic t_sticky();
        do_reset();
        beat(1, 1, 0, 3'b010, 0);
        beat(1, 1, 0, 3'b000, 0);
        beat(1, 1, 0, 3'b011, 0);
        repeat (5) @(negedge clk);
        check_all("R6 first code kept", 0, 0, 0, 0, 1, 1);
    endtask

    task automatic t_clear();
        do_reset();
        beat(1, 1, 1, 3'b000, 0);
        beat(1, 1, 1, 3'b100, 0);
        check_all("R7 before clear", 0, 1, 0, 0, 1, 2);
        beat(0, 0, 0, 3'b000, 1);
        check_all("R7 clear", 0, 1, 0, 0, 0, 0);
        beat(1, 1, 1, 3'b010, 0);
        beat(1, 1, 1, 3'b010, 0);
        beat(1, 1, 1, 3'b010, 0);
        beat(0, 0, 0, 3'b000, 1);
        beat(1, 1, 1, 3'b111, 0);
        check_all("R7 clear keeps position", 0, 1, 0, 1, 0, 0);
        beat(1, 1, 0, 3'b000, 0);
        beat(1, 1, 0, 3'b010, 0);
        beat(1, 1, 0, 3'b000, 0);
        check_all("R7 nested before re-arm", 1, 1, 0, 1, 1, 1);
        beat(1, 1, 0, 3'b101, 1);
        check_all("R7 clear with violation", 1, 1, 0, 1, 1, 2);
    endtask

    task automatic t_saturate();
        do_reset();
        @(negedge clk);
        bus_cyc = 1'b1; bus_ack = 1'b1; bus_we = 1'b0; bus_cti = 3'b000;
        repeat (65534) @(negedge clk);
        check("R8 count before top", single_rd_cnt, 16'hFFFE);
        repeat (3) @(negedge clk);
        bus_cyc = 1'b0; bus_ack = 1'b0;
        check("R8 saturated", single_rd_cnt, 16'hFFFF);
        check("R8 no error", err_flag, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_quiet();
                t_singles();
                t_bursts();
                t_nested();
                t_bad();
                t_sticky();
                t_clear();
                t_saturate();
                done = 1'b1;
            end
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule